// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This block keeps the status byte of a serial EEPROM and rules on every instruction that would change memory or status contents. A front end decodes each instruction into a one-cycle strobe. The block answers each write-type request one clock later with a grant pulse or a deny pulse. It then holds the write-in-progress flag until the self-timed cycle ends. Serial shifting and array storage are outside its scope.

There are two protection mechanisms. The first is a two-bit region code, which guards none, a quarter, half or all of the address space, counted down from the top address. The second is a sticky lock bit. When the lock bit is set and the protect pin is driven low, further status writes are refused. A write-enable latch has to be set before every write. It clears again when the write finishes or is refused.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00, and grant, deny and busy are all 0.
- R2: The status byte layout is: bit 7 lock (SRWD), bit 3 region high bit, bit 2 region low bit, bit 1 enable latch (WEL), bit 0 in-progress flag (WIP). Bits 6 to 4 always read 0.
- R3: A write-enable strobe sets WEL on the following cycle. A write-disable strobe clears it.
- R4: A memory-write strobe issued while WEL is 0 produces a deny pulse one cycle later, and WIP stays 0.
- R5: Region code 00 protects no address. Code 01 protects addresses 0xC000 and above. Code 10 protects 0x8000 and above. Code 11 protects every address. A memory write to a protected address is denied.
- R6: An accepted write produces a grant pulse one cycle after its strobe. WIP reads 1 from that cycle until the cycle after the write-complete strobe. WEL clears together with WIP.
- R7: Any denied write or status write clears WEL.
- R8: A status write is accepted when WEL is 1 and either SRWD is 0 or the protect pin is high. Data bits 7, 3 and 2 become SRWD and the region code once the write completes. All other data bits are ignored.
- R9: When SRWD is 1 and the protect pin is low, a status write is denied and the status byte is left unchanged.
- R10: While WIP is 1, the write-enable, write-disable, status-write and memory-write strobes are ignored.
- R11: A write-complete strobe issued while WIP is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_write | input | 1 | Memory-write strobe |
| cmd_done | input | 1 | Self-timed write finished |
| addr | input | ADDR_W | Target address of a memory write |
| wp_level | input | 1 | Protect pin level (low enables the lock) |
| new_status | input | 8 | Data carried by a status write |
| status_byte | output | 8 | Status byte for reads |
| grant | output | 1 | One-cycle pulse: request accepted |
| deny | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | Write in progress |

## Verification
The assertions assume that the front end raises at most one command strobe per cycle. They also assume that all strobes stay low during reset, because several properties look one cycle back at a strobe. The bench drives a single strobe per cycle from one task, which clears every strobe right after the clock edge. It never raises a strobe while reset is asserted. The protect pin is changed only on cycles that carry no status write.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_write,
  input  logic              cmd_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_level,
  input  logic [7:0]        new_status,
  output logic [7:0]        status_byte,
  output logic              grant,
  output logic              deny,
  output logic              busy
);
  localparam int TOP = ADDR_W - 1;

  logic       srwd, wel, pend_sr, pend_srwd;
  logic [1:0] bp, pend_bp;
  logic       hw_lock, in_zone;

  assign hw_lock = srwd && !wp_level;

  always_comb begin
    unique case (bp)
      2'b00:   in_zone = 1'b0;
      2'b01:   in_zone = &addr[TOP -: 2];
      2'b10:   in_zone = addr[TOP];
      default: in_zone = 1'b1;
    endcase
  end

  assign status_byte = {srwd, 3'b000, bp, wel, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srwd <= 1'b0; bp <= 2'b00; wel <= 1'b0; busy <= 1'b0;
      pend_sr <= 1'b0; pend_srwd <= 1'b0; pend_bp <= 2'b00;
      grant <= 1'b0; deny <= 1'b0;
    end else begin
      grant <= 1'b0;
      deny  <= 1'b0;
      if (busy) begin
        if (cmd_done) begin
          busy    <= 1'b0;
          wel     <= 1'b0;
          pend_sr <= 1'b0;
          if (pend_sr) begin
            srwd <= pend_srwd;
            bp   <= pend_bp;
          end
        end
      end else if (cmd_wren) begin
        wel <= 1'b1;
      end else if (cmd_wrdi) begin
        wel <= 1'b0;
      end else if (cmd_wrsr) begin
        if (wel && !hw_lock) begin
          grant     <= 1'b1;
          busy      <= 1'b1;
          pend_sr   <= 1'b1;
          pend_srwd <= new_status[7];
          pend_bp   <= new_status[3:2];
        end else begin
          deny <= 1'b1;
          wel  <= 1'b0;
        end
      end else if (cmd_write) begin
        if (wel && !in_zone) begin
          grant <= 1'b1;
          busy  <= 1'b1;
        end else begin
          deny <= 1'b1;
          wel  <= 1'b0;
        end
      end
    end
  end
endmodule

module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wrsr,
  input logic       cmd_write,
  input logic       cmd_done,
  input logic       wp_level,
  input logic [7:0] status_byte,
  input logic       grant,
  input logic       deny,
  input logic       busy
);
  a_r6_grant_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (busy && status_byte[0]));

  a_r6_wel_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] |-> status_byte[1]);

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_done) && $past(busy)) |-> (!busy && !status_byte[1]));

  a_r7_deny_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> (!status_byte[1] && !busy));

  a_r9_hw_lock_denies: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_wrsr) && !$past(busy) && $past(status_byte[7]) && !$past(wp_level))
      |-> (deny && !grant));

  a_r5_full_zone_denies: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_write) && !$past(busy) && ($past(status_byte[3:2]) == 2'b11))
      |-> !grant);

  a_r10_busy_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (!grant && !deny));

  a_r4_verdicts_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));
endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write),
  .cmd_done(cmd_done), .wp_level(wp_level), .status_byte(status_byte),
  .grant(grant), .deny(deny), .busy(busy)
);

// File: tb/sr_guard_bench.sv
module sr_guard_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, cmd_done = 0;
  logic [15:0] addr = '0;
  logic wp_level = 1'b1;
  logic [7:0] new_status = '0;
  logic [7:0] status_byte;
  logic grant, deny, busy;

  always #4 clk = ~clk;

  sr_guard #(.ADDR_W(16)) u_sr_guard (.*);

  typedef struct { string tag; logic [7:0] st; logic g; logic d; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // c: 0 idle, 1 wren, 2 wrdi, 3 wrsr, 4 write, 5 done
  task automatic step(int c, logic [15:0] a, logic [7:0] d,
                      logic [7:0] st, logic g, logic dn, string tag);
    exp_t e;
    @(negedge clk);
    cmd_wren = (c == 1); cmd_wrdi = (c == 2); cmd_wrsr = (c == 3);
    cmd_write = (c == 4); cmd_done = (c == 5);
    addr = a; new_status = d;
    @(posedge clk); #1;
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0; cmd_done = 0;
    e.tag = tag; e.st = st; e.g = g; e.d = dn;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (status_byte !== e.st || grant !== e.g || deny !== e.d || busy !== e.st[0]) begin
        errors++;
        $display("FAIL %s: status=%h grant=%b deny=%b busy=%b expected status=%h grant=%b deny=%b",
                 e.tag, status_byte, grant, deny, busy, e.st, e.g, e.d);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0, 8'h00, 0, 0, "R1 reset state");
    step(1, 0, 0, 8'h02, 0, 0, "R3 wren sets WEL");
    step(2, 0, 0, 8'h00, 0, 0, "R3 wrdi clears WEL");
    step(4, 16'h0000, 0, 8'h00, 0, 1, "R4 write without WEL");
    step(1, 0, 0, 8'h02, 0, 0, "R3 wren");
    step(4, 16'h1234, 0, 8'h03, 1, 0, "R6 write accepted");
    step(2, 0, 0, 8'h03, 0, 0, "R10 wrdi ignored while busy");
    step(0, 0, 0, 8'h03, 0, 0, "R6 busy holds");
    step(5, 0, 0, 8'h00, 0, 0, "R6 done clears WIP and WEL");
    step(5, 0, 0, 8'h00, 0, 0, "R11 stray done");
    step(1, 0, 0, 8'h02, 0, 0, "R3 wren");
    step(3, 0, 8'hFF, 8'h03, 1, 0, "R8 status write accepted");
    step(1, 0, 0, 8'h03, 0, 0, "R10 wren ignored while busy");
    step(5, 0, 0, 8'h8C, 0, 0, "R2 R8 new status, bits 6:4 read 0");
    step(1, 0, 0, 8'h8E, 0, 0, "R3 wren");
    step(4, 16'h0000, 0, 8'h8C, 0, 1, "R5 R7 code 11 blocks address 0");
    step(1, 0, 0, 8'h8E, 0, 0, "R3 wren");
    wp_level = 1'b0;
    step(3, 0, 8'h00, 8'h8C, 0, 1, "R9 hardware lock denies status write");
    wp_level = 1'b1;
    step(1, 0, 0, 8'h8E, 0, 0, "R3 wren");
    step(3, 0, 8'h04, 8'h8F, 1, 0, "R8 pin high allows status write");
    step(5, 0, 0, 8'h04, 0, 0, "R8 region code 01");
    step(1, 0, 0, 8'h06, 0, 0, "R3 wren");
    step(4, 16'hC000, 0, 8'h04, 0, 1, "R5 code 01 blocks 0xC000");
    step(1, 0, 0, 8'h06, 0, 0, "R3 wren");
    step(4, 16'hBFFF, 0, 8'h07, 1, 0, "R5 code 01 allows 0xBFFF");
    step(5, 0, 0, 8'h04, 0, 0, "R6 done");
    step(1, 0, 0, 8'h06, 0, 0, "R3 wren");
    step(3, 0, 8'h08, 8'h07, 1, 0, "R8 status write");
    step(5, 0, 0, 8'h08, 0, 0, "R8 region code 10");
    step(1, 0, 0, 8'h0A, 0, 0, "R3 wren");
    step(4, 16'h8000, 0, 8'h08, 0, 1, "R5 code 10 blocks 0x8000");
    step(1, 0, 0, 8'h0A, 0, 0, "R3 wren");
    step(4, 16'h7FFF, 0, 8'h0B, 1, 0, "R5 code 10 allows 0x7FFF");
    step(5, 0, 0, 8'h08, 0, 0, "R6 done");
    wp_level = 1'b0;
    step(1, 0, 0, 8'h0A, 0, 0, "R3 wren");
    step(3, 0, 8'h00, 8'h0B, 1, 0, "R8 SRWD 0 with pin low allows write");
    step(5, 0, 0, 8'h00, 0, 0, "R8 cleared status");
    step(4, 16'h0010, 0, 8'h00, 0, 1, "R4 write without WEL again");
    step(0, 0, 0, 8'h00, 0, 0, "R4 no busy after deny");
    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule